// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-facing front end of a three-channel interval timer. It sits on an 8-bit register bus with four addresses. Three of them are channel data ports and one is a write-only command port. It turns command bytes into per-channel configuration and load strobes. It splits 16-bit reload values and count readouts into byte transfers. It also keeps snapshot registers that let software read a stable count or a status byte while the counter keeps running.

The counters themselves live outside this block. Each channel's counter supplies its live count, its output pin level and a null-count flag. In return it receives its access, mode and number-format setting, a one-cycle pulse whenever it is reprogrammed, and a one-cycle load pulse carrying a complete 16-bit reload value.

A bus cycle is a single clock with `bus_wr` or `bus_rd` high. Read data is combinational from the current state. The side effects of a read, such as advancing the byte phase or releasing a snapshot, take place at the clock edge that ends the cycle. If `bus_wr` and `bus_rd` are both high, the write is performed and the read is ignored.

Top module: `itimer_hostif`

## Requirements
- R1: Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the command port. A read of address 3 returns 0x00. `bus_rdata` is 0x00 whenever `bus_rd` is low.
- R2: A command byte has the channel in bits 7:6, the access field in bits 5:4, the mode in bits 3:1 and the number-format bit in bit 0. A command to channel n (0..2) with a nonzero access field updates `ch_acc`, `ch_mode` and `ch_bcd` of channel n and pulses `ch_cmd[n]` for one cycle, starting the cycle after the write.
- R3: Access field 01 is low-byte-only: a data write of d loads {0x00, d}. Access field 10 is high-byte-only: a data write of d loads {d, 0x00}. `ch_load[n]` pulses with the value on `ch_load_val` the cycle after the write.
- R4: Access field 11 is low-then-high. The first data write is held and produces no load. The second write d2 loads {d2, first byte}, so there is one load pulse per pair.
- R5: Any command that programs a channel resets its write and read byte phases and clears its snapshots, so the next data access is a low byte.
- R6: With no snapshot held, a data read returns the live count of the channel: the low byte for access 01, the high byte for access 10, and for access 11 low and high bytes alternately, starting with low.
- R7: A command with access field 00 snapshots the channel's count. The snapshot is read instead of the live count until it has been completely read under the current access setting (one byte for 01/10, two for 11). Further snapshot requests for that channel are ignored until then.
- R8: A command with bits 7:6 = 11 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2, and any combination may be set. Bit 5 = 0 snapshots the count of every selected channel. Unselected channels are untouched.
- R9: In a read-back, bit 4 = 0 snapshots a status byte for every selected channel: bit 7 output pin, bit 6 null-count flag, bits 5:4 access, bits 3:1 mode, bit 0 number format. The next data read returns it. A second status request before that read is ignored.
- R10: When both a status and a count snapshot are held, the first read returns the status and the following reads return the count bytes.
- R11: After reset every channel has access 11, mode 000 and binary format. Byte phases are low, no snapshots are held, and no load or command pulses are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register address: 0..2 data ports, 3 command port |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ch_count | input | 48 | Live counts, channel n in bits 16n+15:16n |
| ch_out | input | 3 | Output pin level per channel |
| ch_null | input | 3 | Null-count flag per channel |
| ch_acc | output | 6 | Programmed access field, channel n in bits 2n+1:2n |
| ch_mode | output | 9 | Programmed mode, channel n in bits 3n+2:3n |
| ch_bcd | output | 3 | Programmed number-format bit per channel |
| ch_cmd | output | 3 | One-cycle pulse when a channel is reprogrammed |
| ch_load | output | 3 | One-cycle pulse when a complete reload value is ready |
| ch_load_val | output | 48 | Reload value, channel n in bits 16n+15:16n |

## Verification
Read data depends only on the current state and is due in the same cycle `bus_rd` is raised. Its side effects (phase toggling, snapshot release) show on the next read. Configuration outputs, `ch_cmd` and `ch_load` are registered and become valid one cycle after the write edge, then drop the cycle after that. The bench drives every access on a falling edge and samples read data 1 ns later within that cycle. It checks the registered pulses and values at the falling edge that follows the write's rising edge, which is the only cycle in which a pulse is high.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

    localparam int NCH     = 3;
    localparam int CW      = 16;
    localparam int BW      = 8;
    localparam int SELW    = 2;
    localparam int MODEW   = 3;
    localparam logic [SELW-1:0] PORT_CMD = 2'd3;
    localparam logic [1:0]      SEL_RB   = 2'b11;

    typedef enum logic [1:0] {
        ACC_SNAP = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_LOHI = 2'b11
    } acc_e;

    typedef struct packed {
        acc_e             acc;
        logic [MODEW-1:0] mode;
        logic             bcd;
    } chcfg_t;

    localparam chcfg_t RST_CFG = '{acc: ACC_LOHI, mode: '0, bcd: 1'b0};

    function automatic logic [BW-1:0] pick_byte(acc_e acc, logic hi_phase, logic [CW-1:0] val);
        logic use_hi;
        use_hi = (acc == ACC_HI) || ((acc == ACC_LOHI) && hi_phase);
        return use_hi ? val[CW-1:BW] : val[BW-1:0];
    endfunction

    function automatic logic read_ends(acc_e acc, logic hi_phase);
        return (acc != ACC_LOHI) || hi_phase;
    endfunction

    function automatic logic [BW-1:0] status_byte(logic pin, logic nul, chcfg_t cfg);
        return {pin, nul, cfg};
    endfunction

endpackage

// File: rtl/itimer_cmd_dec.sv
module itimer_cmd_dec
    import itimer_pkg::*;
(
    input  logic            wr_en,
    input  logic [SELW-1:0] sel,
    input  logic [BW-1:0]   wdata,
    output logic [NCH-1:0]  prog_stb,
    output logic [NCH-1:0]  lcnt_stb,
    output logic [NCH-1:0]  lst_stb,
    output chcfg_t          new_cfg
);

    logic cmd_hit;
    logic is_rb;

    assign cmd_hit = wr_en && (sel == PORT_CMD);
    assign is_rb   = (wdata[7:6] == SEL_RB);

    always_comb begin
        prog_stb = '0;
        lcnt_stb = '0;
        lst_stb  = '0;
        new_cfg  = '{acc: acc_e'(wdata[5:4]), mode: wdata[3:1], bcd: wdata[0]};
        if (cmd_hit) begin
            for (int i = 0; i < NCH; i++) begin
                if (is_rb) begin
                    if (wdata[i+1]) begin
                        lcnt_stb[i] = ~wdata[5];
                        lst_stb[i]  = ~wdata[4];
                    end
                end else if (wdata[7:6] == 2'(i)) begin
                    if (new_cfg.acc == ACC_SNAP) lcnt_stb[i] = 1'b1;
                    else                         prog_stb[i] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/itimer_chan_regs.sv
module itimer_chan_regs
    import itimer_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          prog_stb,
    input  chcfg_t        new_cfg,
    input  logic          lcnt_stb,
    input  logic          lst_stb,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic [BW-1:0] wdata,
    input  logic [CW-1:0] count_i,
    input  logic          pin_i,
    input  logic          null_i,
    output chcfg_t        cfg_o,
    output logic [BW-1:0] rd_byte_o,
    output logic          load_o,
    output logic [CW-1:0] load_val_o,
    output logic          cmd_o
);

    chcfg_t        cfg_q;
    logic          wr_hi_q;
    logic          rd_hi_q;
    logic [BW-1:0] lo_hold_q;
    logic          cnt_lat_q;
    logic [CW-1:0] cnt_hold_q;
    logic          st_lat_q;
    logic [BW-1:0] st_hold_q;
    logic          load_q;
    logic [CW-1:0] load_val_q;
    logic          cmd_q;
    logic [CW-1:0] cnt_view;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= RST_CFG;
            wr_hi_q    <= 1'b0;
            rd_hi_q    <= 1'b0;
            lo_hold_q  <= '0;
            cnt_lat_q  <= 1'b0;
            cnt_hold_q <= '0;
            st_lat_q   <= 1'b0;
            st_hold_q  <= '0;
            load_q     <= 1'b0;
            load_val_q <= '0;
            cmd_q      <= 1'b0;
        end else begin
            load_q <= 1'b0;
            cmd_q  <= 1'b0;
            if (prog_stb) begin
                cfg_q     <= new_cfg;
                wr_hi_q   <= 1'b0;
                rd_hi_q   <= 1'b0;
                cnt_lat_q <= 1'b0;
                st_lat_q  <= 1'b0;
                cmd_q     <= 1'b1;
            end else begin
                if (wr_stb) begin
                    unique case (cfg_q.acc)
                        ACC_LO: begin
                            load_q     <= 1'b1;
                            load_val_q <= {{BW{1'b0}}, wdata};
                        end
                        ACC_HI: begin
                            load_q     <= 1'b1;
                            load_val_q <= {wdata, {BW{1'b0}}};
                        end
                        ACC_LOHI: begin
                            if (!wr_hi_q) begin
                                lo_hold_q <= wdata;
                                wr_hi_q   <= 1'b1;
                            end else begin
                                load_q     <= 1'b1;
                                load_val_q <= {wdata, lo_hold_q};
                                wr_hi_q    <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
                if (rd_stb) begin
                    if (st_lat_q) begin
                        st_lat_q <= 1'b0;
                    end else begin
                        if (cfg_q.acc == ACC_LOHI) rd_hi_q <= ~rd_hi_q;
                        if (cnt_lat_q && read_ends(cfg_q.acc, rd_hi_q)) cnt_lat_q <= 1'b0;
                    end
                end
                if (lcnt_stb && !cnt_lat_q) begin
                    cnt_lat_q  <= 1'b1;
                    cnt_hold_q <= count_i;
                end
                if (lst_stb && !st_lat_q) begin
                    st_lat_q  <= 1'b1;
                    st_hold_q <= status_byte(pin_i, null_i, cfg_q);
                end
            end
        end
    end

    assign cnt_view   = cnt_lat_q ? cnt_hold_q : count_i;
    assign rd_byte_o  = st_lat_q ? st_hold_q : pick_byte(cfg_q.acc, rd_hi_q, cnt_view);
    assign cfg_o      = cfg_q;
    assign load_o     = load_q;
    assign load_val_o = load_val_q;
    assign cmd_o      = cmd_q;

endmodule

// File: rtl/itimer_hostif.sv
module itimer_hostif
    import itimer_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SELW-1:0]       bus_sel,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [BW-1:0]         bus_wdata,
    output logic [BW-1:0]         bus_rdata,
    input  logic [NCH*CW-1:0]     ch_count,
    input  logic [NCH-1:0]        ch_out,
    input  logic [NCH-1:0]        ch_null,
    output logic [NCH*2-1:0]      ch_acc,
    output logic [NCH*MODEW-1:0]  ch_mode,
    output logic [NCH-1:0]        ch_bcd,
    output logic [NCH-1:0]        ch_cmd,
    output logic [NCH-1:0]        ch_load,
    output logic [NCH*CW-1:0]     ch_load_val
);

    logic          rd_en;
    logic [NCH-1:0] prog_stb;
    logic [NCH-1:0] lcnt_stb;
    logic [NCH-1:0] lst_stb;
    chcfg_t        new_cfg;
    logic [BW-1:0] rd_byte [NCH];

    assign rd_en = bus_rd && !bus_wr;

    itimer_cmd_dec u_dec (
        .wr_en    (bus_wr),
        .sel      (bus_sel),
        .wdata    (bus_wdata),
        .prog_stb (prog_stb),
        .lcnt_stb (lcnt_stb),
        .lst_stb  (lst_stb),
        .new_cfg  (new_cfg)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chcfg_t cfg;
        logic   wr_stb;
        logic   rd_stb;

        assign wr_stb = bus_wr && (bus_sel == SELW'(g));
        assign rd_stb = rd_en  && (bus_sel == SELW'(g));

        itimer_chan_regs u_regs (
            .clk        (clk),
            .rst        (rst),
            .prog_stb   (prog_stb[g]),
            .new_cfg    (new_cfg),
            .lcnt_stb   (lcnt_stb[g]),
            .lst_stb    (lst_stb[g]),
            .wr_stb     (wr_stb),
            .rd_stb     (rd_stb),
            .wdata      (bus_wdata),
            .count_i    (ch_count[g*CW +: CW]),
            .pin_i      (ch_out[g]),
            .null_i     (ch_null[g]),
            .cfg_o      (cfg),
            .rd_byte_o  (rd_byte[g]),
            .load_o     (ch_load[g]),
            .load_val_o (ch_load_val[g*CW +: CW]),
            .cmd_o      (ch_cmd[g])
        );

        assign ch_acc[g*2 +: 2]          = cfg.acc;
        assign ch_mode[g*MODEW +: MODEW] = cfg.mode;
        assign ch_bcd[g]                 = cfg.bcd;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (bus_sel == SELW'(i)) bus_rdata = rd_byte[i];
            end
        end
    end

endmodule

// File: rtl/itimer_hostif_chk.sv
module itimer_hostif_chk
    import itimer_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [SELW-1:0]      bus_sel,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [BW-1:0]        bus_wdata,
    input logic [BW-1:0]        bus_rdata,
    input logic [NCH*MODEW-1:0] ch_mode,
    input logic [NCH-1:0]       ch_cmd,
    input logic [NCH-1:0]       ch_load
);

    p_idle_rdata_r1: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> bus_rdata == '0);

    p_cmdport_read_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_sel == PORT_CMD) |-> bus_rdata == '0);

    p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_sel == PORT_CMD && bus_wdata[7:6] == 2'b00 && bus_wdata[5:4] != 2'b00)
        |=> (ch_cmd[0] && ch_mode[MODEW-1:0] == $past(bus_wdata[3:1])));

    p_load_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_load));

    for (genvar g = 0; g < NCH; g++) begin : g_src
        p_load_source_r4: assert property (@(posedge clk) disable iff (rst)
            ch_load[g] |-> $past(bus_wr && bus_sel == SELW'(g)));
    end

    p_cmd_no_load_r5: assert property (@(posedge clk) disable iff (rst)
        (|ch_cmd) |-> ch_load == '0);

endmodule

bind itimer_hostif itimer_hostif_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ch_mode   (ch_mode),
    .ch_cmd    (ch_cmd),
    .ch_load   (ch_load)
);

// File: tb/test_itimer_hostif.sv
`timescale 1ns/1ps
module test_itimer_hostif;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_sel = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] ch_count = '0;
    logic [2:0]  ch_out = '0;
    logic [2:0]  ch_null = '0;
    logic [5:0]  ch_acc;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;
    logic [2:0]  ch_cmd;
    logic [2:0]  ch_load;
    logic [47:0] ch_load_val;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    itimer_hostif i_itimer_hostif (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_count(ch_count),
        .ch_out(ch_out), .ch_null(ch_null), .ch_acc(ch_acc), .ch_mode(ch_mode),
        .ch_bcd(ch_bcd), .ch_cmd(ch_cmd), .ch_load(ch_load), .ch_load_val(ch_load_val)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 2'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 2'(a); bus_rd = 1'b1;
        #1;
        chk(tag, 32'(bus_rdata), 32'(exp));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cnt(input int ch, input logic [15:0] v);
        ch_count[ch*16 +: 16] = v;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            nbad++;
            nvec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 acc", 32'(ch_acc), 32'h3F);
        chk("R11 mode", 32'(ch_mode), 32'h0);
        chk("R11 bcd", 32'(ch_bcd), 32'h0);
        chk("R11 load", 32'(ch_load), 32'h0);
        chk("R11 cmd", 32'(ch_cmd), 32'h0);
        chk("R1 idle rdata", 32'(bus_rdata), 32'h0);
        set_cnt(0, 16'hC0DE);
        rd(0, 8'hDE, "R11 first read low");
        rd(0, 8'hC0, "R11 second read high");
        rd(3, 8'h00, "R1 command port read");

        // R2/R3/R4/R6 sweep: every channel, access mode and mode
        for (int ch = 0; ch < 3; ch++) begin
            for (int acc = 1; acc < 4; acc++) begin
                for (int md = 0; md < 6; md++) begin
                    logic        bcd;
                    logic [15:0] v;
                    bcd = 1'(md) ^ 1'(ch);
                    v = 16'h1234 + 16'(ch) * 16'h0101 + 16'(acc) * 16'h1111 + 16'(md) * 16'd37;
                    wr(3, {2'(ch), 2'(acc), 3'(md), bcd});
                    chk("R2 cmd pulse", 32'(ch_cmd), 32'(3'b1 << ch));
                    chk("R2 mode", 32'(ch_mode[ch*3 +: 3]), 32'(md));
                    chk("R2 acc", 32'(ch_acc[ch*2 +: 2]), 32'(acc));
                    chk("R2 bcd", 32'(ch_bcd[ch]), 32'(bcd));
                    if (acc == 1) begin
                        wr(ch, v[7:0]);
                        chk("R3 lo load", 32'(ch_load), 32'(3'b1 << ch));
                        chk("R3 lo val", 32'(ch_load_val[ch*16 +: 16]), 32'({8'h00, v[7:0]}));
                    end else if (acc == 2) begin
                        wr(ch, v[15:8]);
                        chk("R3 hi load", 32'(ch_load), 32'(3'b1 << ch));
                        chk("R3 hi val", 32'(ch_load_val[ch*16 +: 16]), 32'({v[15:8], 8'h00}));
                    end else begin
                        wr(ch, v[7:0]);
                        chk("R4 no load after first", 32'(ch_load), 32'h0);
                        wr(ch, v[15:8]);
                        chk("R4 pair load", 32'(ch_load), 32'(3'b1 << ch));
                        chk("R4 pair val", 32'(ch_load_val[ch*16 +: 16]), 32'(v));
                    end
                    set_cnt(ch, ~v);
                    if (acc == 1) rd(ch, ~v[7:0], "R6 live lo");
                    else if (acc == 2) rd(ch, ~v[15:8], "R6 live hi");
                    else begin
                        rd(ch, ~v[7:0], "R6 live pair lo");
                        rd(ch, ~v[15:8], "R6 live pair hi");
                    end
                end
            end
        end

        // R5: command resets byte phases
        wr(3, 8'h70);
        wr(1, 8'hAA);
        wr(3, 8'h70);
        wr(1, 8'h11);
        chk("R5 write phase reset", 32'(ch_load), 32'h0);
        wr(1, 8'h22);
        chk("R5 load after reset", 32'(ch_load_val[31:16]), 32'h2211);
        set_cnt(1, 16'h5A3C);
        rd(1, 8'h3C, "R5 read lo");
        wr(3, 8'h70);
        rd(1, 8'h3C, "R5 read phase reset");

        // R7: count snapshot, repeat ignored
        wr(3, 8'h30);
        set_cnt(0, 16'h1357);
        wr(3, 8'h00);
        set_cnt(0, 16'h2468);
        wr(3, 8'h00);
        chk("R7 no cmd pulse", 32'(ch_cmd), 32'h0);
        rd(0, 8'h57, "R7 frozen lo");
        set_cnt(0, 16'hBEEF);
        rd(0, 8'h13, "R7 frozen hi");
        rd(0, 8'hEF, "R7 released live");
        wr(3, 8'h90);
        set_cnt(2, 16'h00C3);
        wr(3, 8'h80);
        set_cnt(2, 16'h0077);
        rd(2, 8'hC3, "R7 single byte snapshot");
        rd(2, 8'h77, "R7 single byte release");

        // R8: read-back of counts on channels 0 and 2
        wr(3, 8'h30); wr(3, 8'h70); wr(3, 8'hB0);
        set_cnt(0, 16'h1111); set_cnt(1, 16'h2222); set_cnt(2, 16'h3333);
        wr(3, 8'hDA);
        set_cnt(0, 16'h4444); set_cnt(1, 16'h5566); set_cnt(2, 16'h7788);
        rd(0, 8'h11, "R8 ch0 lo"); rd(0, 8'h11, "R8 ch0 hi");
        rd(1, 8'h66, "R8 ch1 unselected live");
        rd(2, 8'h33, "R8 ch2 lo"); rd(2, 8'h33, "R8 ch2 hi");
        rd(2, 8'h88, "R8 ch2 released");

        // R9: status byte sweep and repeat ignored
        for (int ch = 0; ch < 3; ch++) begin
            for (int k = 0; k < 4; k++) begin
                wr(3, {2'(ch), 6'b110100});
                ch_out[ch] = k[1];
                ch_null[ch] = k[0];
                wr(3, 8'hE0 | 8'(2 << ch));
                rd(ch, {k[1], k[0], 6'b110100}, "R9 status byte");
            end
        end
        wr(3, 8'h67);
        ch_out[1] = 1'b1; ch_null[1] = 1'b0;
        wr(3, 8'hE4);
        ch_out[1] = 1'b0;
        wr(3, 8'hE4);
        set_cnt(1, 16'h9A01);
        rd(1, 8'hA7, "R9 first status kept");
        rd(1, 8'h9A, "R9 status released");

        // R10: status before count
        wr(3, 8'h30);
        set_cnt(0, 16'hA55A);
        ch_out[0] = 1'b1; ch_null[0] = 1'b1;
        wr(3, 8'hC2);
        set_cnt(0, 16'h0F0F);
        rd(0, 8'hF0, "R10 status first");
        rd(0, 8'h5A, "R10 count lo");
        rd(0, 8'hA5, "R10 count hi");
        rd(0, 8'h0F, "R10 released");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule